// File: doc/BRIEF.md
# Dual-Pipeline Register Shadowing Router

This block steers memory-mapped register accesses for a controller with two register pipelines, called A and B. Each pipeline owns a bank of byte-wide registers. The low indices of the bank are one common copy used by both pipelines. The remaining indices are private to each pipeline. The block decodes two 4 MiB windows in a 24-bit memory space. The window at 400000h–7FFFFFh is the A window and the window at C00000h–FFFFFFh is the B window. Each access is sent to bank A, to bank B, or to neither.

A one-byte mode register sits on a separate I/O port at address 3CBh and controls the routing. Bit 3 turns shadowing on. Bit 2 picks which pipeline serves reads. Bit 1 lets writes reach bank A, and bit 0 lets writes reach bank B. When shadowing is off, each window reaches only its own pipeline. When shadowing is on, both windows read the chosen pipeline, and each pipeline accepts writes only through its own window and only while its write bit is set.

Every access, on either port, is accepted in the cycle its valid is high. It completes with a one-cycle ready pulse on the next cycle, and the read data is valid in that same cycle.

Top module: `shadow_router`

## Requirements
- R1: After reset the mode register and every bank register are 00h. Reading I/O address 3CBh returns 00h, and routing is direct (R3).
- R2: An I/O write to 3CBh stores bits 3:0 and drops bits 7:4, and a read of 3CBh returns {4'b0, stored bits}. I/O accesses to any other address are acknowledged, change nothing and read 00h.
- R3: With mode bit 3 = 0, the A window (address bits 23:22 = 01) reads and writes only bank A, and the B window (bits 23:22 = 11) reads and writes only bank B. Mode bits 2:0 have no effect.
- R4: With bit 3 = 1, a read through either window returns bank A when bit 2 = 0 and bank B when bit 2 = 1. The exclusive registers of the other pipeline cannot be read.
- R5: With bit 3 = 1, a write reaches bank A only through the A window and only while bit 1 = 1. Otherwise it is dropped.
- R6: With bit 3 = 1, a write reaches bank B only through the B window and only while bit 0 = 1. Otherwise it is dropped.
- R7: The register index is address bits 3:0. Indices 0–3 are one shared copy, which both banks read and either permitted write path updates. Indices 4–15 are separate per bank.
- R8: Memory accesses with address bits 23:22 = 00 or 10 are acknowledged, change no register and read 00h.
- R9: Each access raises its port's ready for exactly one cycle, in the cycle after valid. Read data is presented in that cycle, and read data is 00h on write completions and whenever ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memValid | input | 1 | Memory access request |
| memWrite | input | 1 | 1 = write, 0 = read |
| memAddr | input | 24 | Memory byte address |
| memWdata | input | 8 | Memory write data |
| memRdata | output | 8 | Memory read data, valid with memReady |
| memReady | output | 1 | Memory access completion pulse |
| ioValid | input | 1 | I/O access request |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 16 | I/O address |
| ioWdata | input | 8 | I/O write data |
| ioRdata | output | 8 | I/O read data, valid with ioReady |
| ioReady | output | 1 | I/O access completion pulse |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 16 registers per bank with the lowest four shared, and the mode register at 3CBh. With these values all sixteen mode-register settings can be swept within a short run. Under each setting, writes and cross-window reads hit both a shared index and private indices, and every combination of read source and per-pipeline write gate is compared with an independent routing model. Accesses outside the windows, I/O writes to neighbouring addresses and set reserved bits are also driven, so that dropped accesses show up in later reads.

// File: rtl/shadow_router_pkg.sv
package shadow_router_pkg;
  localparam int DATA_W      = 8;
  localparam int BANK_REGS   = 16;
  localparam int SHARED_REGS = 4;
  localparam int IDX_W       = $clog2(BANK_REGS);

  // Strobes from the control path to the register datapath
  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic             rdA;
    logic             rdB;
    logic [IDX_W-1:0] idx;
  } bankStrobe_t;
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_router_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter int          IOADR_W = 16,
  parameter logic [15:0] MODE_IO = 16'h03CB
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               memValid,
  input  logic               memWrite,
  input  logic [ADDR_W-1:0]  memAddr,
  output logic               memReady,
  input  logic               ioValid,
  input  logic               ioWrite,
  input  logic [IOADR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0]  ioWdata,
  output logic [DATA_W-1:0]  ioRdata,
  output logic               ioReady,
  output bankStrobe_t        strobe
);
  localparam logic [1:0] WIN_A = 2'b01;
  localparam logic [1:0] WIN_B = 2'b11;
  localparam int         MODE_W = 4;

  logic [MODE_W-1:0] modeReg;
  logic shadowOn, readSelB, wrEnA, wrEnB;
  logic inWinA, inWinB, ioHit, memRd, memWr;
  logic unusedBits;

  assign shadowOn = modeReg[3];
  assign readSelB = modeReg[2];
  assign wrEnA    = modeReg[1];
  assign wrEnB    = modeReg[0];

  assign inWinA = (memAddr[ADDR_W-1 -: 2] == WIN_A);
  assign inWinB = (memAddr[ADDR_W-1 -: 2] == WIN_B);
  assign memRd  = memValid && !memWrite;
  assign memWr  = memValid && memWrite;
  assign ioHit  = (ioAddr == MODE_IO[IOADR_W-1:0]);
  assign unusedBits = ^{memAddr[ADDR_W-3:IDX_W], ioWdata[DATA_W-1:MODE_W]};

  always_comb begin
    strobe     = '0;
    strobe.idx = memAddr[IDX_W-1:0];
    if (!shadowOn) begin
      strobe.rdA = memRd && inWinA;
      strobe.rdB = memRd && inWinB;
      strobe.wrA = memWr && inWinA;
      strobe.wrB = memWr && inWinB;
    end else begin
      strobe.rdA = memRd && (inWinA || inWinB) && !readSelB;
      strobe.rdB = memRd && (inWinA || inWinB) && readSelB;
      strobe.wrA = memWr && inWinA && wrEnA;
      strobe.wrB = memWr && inWinB && wrEnB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      ioRdata  <= '0;
      ioReady  <= 1'b0;
      memReady <= 1'b0;
    end else begin
      memReady <= memValid;
      ioReady  <= ioValid;
      if (ioValid && ioWrite && ioHit)
        modeReg <= ioWdata[MODE_W-1:0];
      ioRdata <= (ioValid && !ioWrite && ioHit)
                 ? {{(DATA_W-MODE_W){1'b0}}, modeReg} : '0;
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [BANK_REGS-1:0][DATA_W-1:0] viewA;
  logic [BANK_REGS-1:0][DATA_W-1:0] viewB;

  for (genvar i = 0; i < BANK_REGS; i++) begin : g_entry
    logic hit;
    assign hit = (strobe.idx == i[IDX_W-1:0]);
    if (i < SHARED_REGS) begin : g_common
      logic [DATA_W-1:0] common;
      always_ff @(posedge clk) begin
        if (!rstN)                                common <= '0;
        else if (hit && (strobe.wrA || strobe.wrB)) common <= wdata;
      end
      assign viewA[i] = common;
      assign viewB[i] = common;
    end else begin : g_private
      logic [DATA_W-1:0] ownA, ownB;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ownA <= '0;
          ownB <= '0;
        end else begin
          if (hit && strobe.wrA) ownA <= wdata;
          if (hit && strobe.wrB) ownB <= wdata;
        end
      end
      assign viewA[i] = ownA;
      assign viewB[i] = ownB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdata <= '0;
    else if (strobe.rdA) rdata <= viewA[strobe.idx];
    else if (strobe.rdB) rdata <= viewB[strobe.idx];
    else                 rdata <= '0;
  end
endmodule

// File: rtl/shadow_router.sv
module shadow_router
  import shadow_router_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter int          IOADR_W = 16,
  parameter logic [15:0] MODE_IO = 16'h03CB
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               memValid,
  input  logic               memWrite,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memWdata,
  output logic [DATA_W-1:0]  memRdata,
  output logic               memReady,
  input  logic               ioValid,
  input  logic               ioWrite,
  input  logic [IOADR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0]  ioWdata,
  output logic [DATA_W-1:0]  ioRdata,
  output logic               ioReady
);
  bankStrobe_t strobe;

  shadow_ctrl #(.ADDR_W(ADDR_W), .IOADR_W(IOADR_W), .MODE_IO(MODE_IO)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memReady(memReady),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioRdata(ioRdata), .ioReady(ioReady), .strobe(strobe)
  );

  shadow_bank u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(memWdata), .rdata(memRdata)
  );
endmodule

// File: rtl/shadow_router_chk.sv
module shadow_router_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memRdata,
  input logic              memReady,
  input logic              ioValid,
  input logic [7:0]        ioRdata,
  input logic              ioReady
);
  // R9
  mem_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReady == $past(memValid));
  // R9
  io_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioReady == $past(ioValid));
  // R9
  idle_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memReady |-> memRdata == 8'h00);
  // R9
  write_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReady && $past(memWrite)) |-> memRdata == 8'h00);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioRdata[7:4] == 4'h0);
  // R8
  outside_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReady && $past(!memAddr[ADDR_W-2])) |-> memRdata == 8'h00);
endmodule

bind shadow_router shadow_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memValid(memValid), .memWrite(memWrite),
  .memAddr(memAddr), .memRdata(memRdata), .memReady(memReady),
  .ioValid(ioValid), .ioRdata(ioRdata), .ioReady(ioReady)
);

// File: tb/test_shadow_router.sv
module test_shadow_router;
  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memValid = 1'b0, memWrite = 1'b0;
  logic [23:0] memAddr = '0;
  logic [7:0]  memWdata = '0;
  logic [7:0]  memRdata;
  logic        memReady;
  logic        ioValid = 1'b0, ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        ioReady;

  int checks = 0;
  int errors = 0;
  item_t memQ[$];
  item_t ioQ[$];

  // Reference model
  logic [3:0] refMode = '0;
  logic [7:0] refCommon [4];
  logic [7:0] refOwnA [16];
  logic [7:0] refOwnB [16];

  always #10 clk = ~clk;

  shadow_router i_shadow_router (
    .clk(clk), .rstN(rstN),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ioReady(ioReady)
  );

  function automatic logic [7:0] refRead(input logic [23:0] a);
    logic useB;
    int   idx;
    idx = int'(a[3:0]);
    if (a[22] == 1'b0) return 8'h00;
    useB = refMode[3] ? refMode[2] : a[23];
    if (idx < 4) return refCommon[idx];
    return useB ? refOwnB[idx] : refOwnA[idx];
  endfunction

  function automatic void refWrite(input logic [23:0] a, input logic [7:0] d);
    logic toA, toB;
    int   idx;
    idx = int'(a[3:0]);
    toA = (a[23:22] == 2'b01) && (!refMode[3] || refMode[1]);
    toB = (a[23:22] == 2'b11) && (!refMode[3] || refMode[0]);
    if (toA || toB) begin
      if (idx < 4)  refCommon[idx] = d;
      else if (toA) refOwnA[idx] = d;
      else          refOwnB[idx] = d;
    end
  endfunction

  task automatic memAcc(input logic wr, input logic [23:0] a,
                        input logic [7:0] d, input string req);
    item_t it;
    @(negedge clk);
    memValid = 1'b1; memWrite = wr; memAddr = a; memWdata = d;
    if (wr) begin
      refWrite(a, d);
      it.exp = 8'h00; it.req = "R9";
    end else begin
      it.exp = refRead(a); it.req = req;
    end
    memQ.push_back(it);
    @(negedge clk);
    memValid = 1'b0; memWrite = 1'b0;
  endtask

  task automatic ioAcc(input logic wr, input logic [15:0] a,
                       input logic [7:0] d, input string req);
    item_t it;
    @(negedge clk);
    ioValid = 1'b1; ioWrite = wr; ioAddr = a; ioWdata = d;
    if (wr && a == 16'h03CB) refMode = d[3:0];
    it.exp = (!wr && a == 16'h03CB) ? {4'h0, refMode} : 8'h00;
    it.req = req;
    ioQ.push_back(it);
    @(negedge clk);
    ioValid = 1'b0; ioWrite = 1'b0;
  endtask

  // Monitors: pop expected items as completions appear
  always @(negedge clk) begin
    if (rstN && memReady) begin
      checks++;
      if (memQ.size() == 0) begin
        errors++;
        $display("FAIL R9 mem: unexpected ready, actual 1 expected 0");
      end else begin
        item_t it;
        it = memQ.pop_front();
        if (memRdata !== it.exp) begin
          errors++;
          $display("FAIL %s mem @%06h: actual %02h expected %02h",
                   it.req, memAddr, memRdata, it.exp);
        end
      end
    end
    if (rstN && ioReady) begin
      checks++;
      if (ioQ.size() == 0) begin
        errors++;
        $display("FAIL R9 io: unexpected ready, actual 1 expected 0");
      end else begin
        item_t it;
        it = ioQ.pop_front();
        if (ioRdata !== it.exp) begin
          errors++;
          $display("FAIL %s io: actual %02h expected %02h", it.req, ioRdata, it.exp);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) refCommon[i] = '0;
    for (int i = 0; i < 16; i++) begin refOwnA[i] = '0; refOwnB[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    ioAcc(1'b0, 16'h03CB, 8'h00, "R1");
    memAcc(1'b0, 24'h400005, 8'h00, "R1");
    memAcc(1'b0, 24'hC00002, 8'h00, "R1");

    // Seed banks with shadowing off (R3, R7)
    for (int i = 0; i < 16; i++) memAcc(1'b1, 24'hC00000 | 24'(i), 8'hB0 + 8'(i), "R3");
    for (int i = 0; i < 16; i++) memAcc(1'b1, 24'h400000 | 24'(i), 8'hA0 + 8'(i), "R3");
    for (int i = 0; i < 16; i++) begin
      memAcc(1'b0, 24'h7FFF00 | 24'(i), 8'h00, i < 4 ? "R7" : "R3");
      memAcc(1'b0, 24'hFAB010 | 24'(i), 8'h00, i < 4 ? "R7" : "R3");
    end

    // R2: reserved bits, other I/O addresses
    ioAcc(1'b1, 16'h03CB, 8'hF0, "R2");
    ioAcc(1'b0, 16'h03CB, 8'h00, "R2");
    ioAcc(1'b1, 16'h03CC, 8'h0F, "R2");
    ioAcc(1'b0, 16'h03CB, 8'h00, "R2");
    ioAcc(1'b0, 16'h03CC, 8'h00, "R2");

    // R8: outside windows
    memAcc(1'b1, 24'h000005, 8'h5A, "R8");
    memAcc(1'b1, 24'h800006, 8'h5B, "R8");
    memAcc(1'b0, 24'h000005, 8'h00, "R8");
    memAcc(1'b0, 24'hBFFFF6, 8'h00, "R8");
    memAcc(1'b0, 24'h400005, 8'h00, "R8");
    memAcc(1'b0, 24'hC00006, 8'h00, "R8");

    // Sweep every mode setting
    for (int m = 0; m < 16; m++) begin
      ioAcc(1'b1, 16'h03CB, {4'hA, 4'(m)}, "R2");
      ioAcc(1'b0, 16'h03CB, 8'h00, "R2");
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < 4; k++) begin
          logic [3:0]  idx;
          logic [23:0] own, other;
          string       wtag, rtag;
          idx   = (k == 0) ? 4'd2 : (k == 1) ? 4'd4 : (k == 2) ? 4'd9 : 4'd15;
          own   = (w == 0) ? (24'h412340 | 24'(idx)) : (24'hC56780 | 24'(idx));
          other = (w == 0) ? (24'hC00000 | 24'(idx)) : (24'h400000 | 24'(idx));
          if (m < 8)       wtag = "R3";
          else if (w == 0) wtag = "R5";
          else             wtag = "R6";
          if (idx < 4)     wtag = "R7";
          rtag = (m < 8) ? "R3" : (idx < 4) ? "R7" : "R4";
          memAcc(1'b1, own, 8'(m * 16 + w * 8 + k + 1), wtag);
          memAcc(1'b0, own, 8'h00, wtag);
          memAcc(1'b0, other, 8'h00, rtag);
        end
      end
      memAcc(1'b0, 24'h000004, 8'h00, "R8");
    end

    repeat (4) @(negedge clk);
    checks++;
    if (memQ.size() != 0 || ioQ.size() != 0) begin
      errors++;
      $display("FAIL R9: pending completions actual %0d expected 0",
               memQ.size() + ioQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule